// File: doc/BRIEF.md
# SMBus Register Bank Slave

This block is a serial-bus target that gives a host access to a bank of 8-bit configuration registers over a two-wire SMBus-compatible link. It recognises its own 7-bit device address and accepts four transaction shapes: an indexed single-byte write, an indexed single-byte read, a counted block write and a counted block read. The first byte after the address is a command byte. Its top bit picks indexed access or block access, and in indexed access its low seven bits give the register index.

The register storage sits outside the block. The block drives a write strobe, a write index and a write byte, and it presents a read index whose data must come back combinationally. SCL and SDA are sampled with a fast system clock through synchronisers. The block only ever pulls SDA low, through an output-enable pin, and it never holds SCL.

Top module: `smb_regbank_slave`

## Requirements
- R1: A byte of 0xD2 (device address 69h with write) or 0xD3 (with read) after a start is acknowledged. Any other address byte is not acknowledged, and the block then leaves SDA released and writes nothing until the next start.
- R2: Command bit 7 set to 1 selects indexed access with the index in bits 6:0. Bit 7 set to 0 selects block access beginning at index 0.
- R3: In an indexed write, the first data byte goes to the selected index. Any further data bytes are acknowledged and discarded.
- R4: In an indexed read (command write, repeated start, address with read bit 1), the block returns the selected register most significant bit first.
- R5: In a block write, the byte after the command is a count, and up to that many following bytes are written to ascending indices starting at 0. Bytes beyond the count are acknowledged and discarded.
- R6: In a block read, the first byte returned equals the register count (NREG), followed by registers 0, 1, 2 and so on. A master ACK (SDA low) asks for the next byte, and a master NACK (SDA high) makes the block release SDA and wait for a stop or a start.
- R7: A write to an index of NREG or above is acknowledged but produces no write strobe. A read from such an index returns 00h.
- R8: The block only changes its SDA drive while SCL is low, and it releases SDA whenever it is idle.
- R9: Out of reset, SDA is released and the write strobe is low.
- R10: Each accepted data byte produces a write strobe lasting exactly one clock cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL level seen on the bus |
| sda_i | input | 1 | SDA level seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_waddr | output | $clog2(NREG) | Register write index |
| reg_wdata | output | 8 | Register write byte |
| reg_raddr | output | $clog2(NREG) | Register read index |
| reg_rdata | input | 8 | Read data for reg_raddr, combinational |

## Verification
A table of indexed write/read pairs uses in-range and out-of-range indices and data patterns with all bits set, no bits set, alternating bits and single edge bits. These patterns separate index decoding faults, bit-order faults and range-check faults. Directed sequences then send a foreign address followed by data, a block write that runs past its count, a block read that is ended by a NACK, and an indexed write with extra bytes. These show whether the count, the starting index and the discard rules are applied. A bus monitor checks that every change of the SDA drive happens while SCL is low, and another checks that every write strobe lasts exactly one cycle.

// File: rtl/smb_slave_pkg.sv
package smb_slave_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RX,
    S_RX_DONE,
    S_RX_ACK,
    S_TX,
    S_TX_ACK,
    S_TX_NEXT,
    S_SKIP
  } smb_state_e;

  typedef enum logic [1:0] {
    ROLE_ADDR,
    ROLE_CMD,
    ROLE_CNT,
    ROLE_DATA
  } smb_role_e;

endpackage

// File: rtl/smb_rst_sync.sv
module smb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2,
  parameter int W      = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);

  for (genvar gi = 0; gi < W; gi++) begin : g_line
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q <= '1;
        prev_q  <= 1'b1;
      end else begin
        chain_q <= {chain_q[STAGES-2:0], din[gi]};
        prev_q  <= chain_q[STAGES-1];
      end
    end

    assign lvl[gi]  = chain_q[STAGES-1];
    assign rise[gi] = chain_q[STAGES-1] & ~prev_q;
    assign fall[gi] = ~chain_q[STAGES-1] & prev_q;
  end

endmodule

// File: rtl/smb_rd_sel.sv
module smb_rd_sel #(
  parameter int NREG  = 32,
  parameter int PTR_W = 8
) (
  input  logic [PTR_W-1:0] ptr,
  input  logic             send_cnt,
  input  logic [7:0]       rdata,
  output logic             in_range,
  output logic [7:0]       tx_byte
);

  localparam logic [7:0]     CNT_BYTE = 8'(NREG);
  localparam logic [PTR_W:0] LIMIT    = (PTR_W+1)'(NREG);

  always_comb begin
    in_range = ({1'b0, ptr} < LIMIT);
    if (send_cnt) begin
      tx_byte = CNT_BYTE;
    end else if (in_range) begin
      tx_byte = rdata;
    end else begin
      tx_byte = 8'h00;
    end
  end

endmodule

// File: rtl/smb_regbank_slave.sv
module smb_regbank_slave
  import smb_slave_pkg::*;
#(
  parameter int         NREG        = 32,
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int         SYNC_STAGES = 2,
  localparam int        IDX_W       = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  output logic             reg_we,
  output logic [IDX_W-1:0] reg_waddr,
  output logic [7:0]       reg_wdata,
  output logic [IDX_W-1:0] reg_raddr,
  input  logic [7:0]       reg_rdata
);

  localparam int PTR_W = 8;

  logic       srst_n;
  logic [1:0] line_lvl, line_rise, line_fall;
  logic       scl_rise, scl_fall, sda_lvl, start_evt, stop_evt;

  smb_rst_sync #(.STAGES(2)) rst_i (
    .clk        (clk),
    .arst_n     (rst_n),
    .rst_n_sync (srst_n)
  );

  smb_line_sync #(.STAGES(SYNC_STAGES), .W(2)) sync_i (
    .clk   (clk),
    .rst_n (srst_n),
    .din   ({sda_i, scl_i}),
    .lvl   (line_lvl),
    .rise  (line_rise),
    .fall  (line_fall)
  );

  assign scl_rise  = line_rise[0];
  assign scl_fall  = line_fall[0];
  assign sda_lvl   = line_lvl[1];
  assign start_evt = line_fall[1] & line_lvl[0] & ~line_rise[0];
  assign stop_evt  = line_rise[1] & line_lvl[0] & ~line_rise[0];

  smb_state_e       state_q, state_d;
  smb_role_e        role_q, role_d;
  logic [2:0]       bcnt_q, bcnt_d;
  logic [7:0]       shreg_q, shreg_d;
  logic             rw_q, rw_d;
  logic [PTR_W-1:0] ptr_q, ptr_d, ptr_next;
  logic             send_cnt_q, send_cnt_d;
  logic [7:0]       wr_left_q, wr_left_d;
  logic             oe_q, oe_d;
  logic             we_q, we_d;
  logic [IDX_W-1:0] waddr_q, waddr_d;
  logic [7:0]       wdata_q, wdata_d;
  logic             in_range, load_tx;
  logic [7:0]       tx_byte;

  smb_rd_sel #(.NREG(NREG), .PTR_W(PTR_W)) rd_sel_i (
    .ptr      (ptr_q),
    .send_cnt (send_cnt_q),
    .rdata    (reg_rdata),
    .in_range (in_range),
    .tx_byte  (tx_byte)
  );

  assign ptr_next = (ptr_q == '1) ? ptr_q : ptr_q + 1'b1;

  always_comb begin
    state_d    = state_q;
    role_d     = role_q;
    bcnt_d     = bcnt_q;
    shreg_d    = shreg_q;
    rw_d       = rw_q;
    ptr_d      = ptr_q;
    send_cnt_d = send_cnt_q;
    wr_left_d  = wr_left_q;
    oe_d       = oe_q;
    we_d       = 1'b0;
    waddr_d    = waddr_q;
    wdata_d    = wdata_q;
    load_tx    = 1'b0;
    if (stop_evt) begin
      state_d = S_IDLE;
      oe_d    = 1'b0;
    end else if (start_evt) begin
      state_d = S_RX;
      role_d  = ROLE_ADDR;
      bcnt_d  = 3'd0;
      oe_d    = 1'b0;
    end else begin
      case (state_q)
        S_RX: begin
          if (scl_rise) begin
            shreg_d = {shreg_q[6:0], sda_lvl};
            if (bcnt_q == 3'd7) begin
              state_d = S_RX_DONE;
            end else begin
              bcnt_d = bcnt_q + 3'd1;
            end
          end
        end
        S_RX_DONE: begin
          if (scl_fall) begin
            state_d = S_RX_ACK;
            oe_d    = 1'b1;
            case (role_q)
              ROLE_ADDR: begin
                if (shreg_q[7:1] != DEV_ADDR) begin
                  state_d = S_SKIP;
                  oe_d    = 1'b0;
                end else begin
                  rw_d = shreg_q[0];
                end
              end
              ROLE_CMD: begin
                if (shreg_q[7]) begin
                  ptr_d      = {1'b0, shreg_q[6:0]};
                  send_cnt_d = 1'b0;
                  wr_left_d  = 8'd1;
                end else begin
                  ptr_d      = '0;
                  send_cnt_d = 1'b1;
                  wr_left_d  = 8'd0;
                end
              end
              ROLE_CNT: wr_left_d = shreg_q;
              default: begin
                if (wr_left_q != 8'd0) begin
                  wr_left_d = wr_left_q - 8'd1;
                  ptr_d     = ptr_next;
                  if (in_range) begin
                    we_d    = 1'b1;
                    waddr_d = ptr_q[IDX_W-1:0];
                    wdata_d = shreg_q;
                  end
                end
              end
            endcase
          end
        end
        S_RX_ACK: begin
          if (scl_fall) begin
            oe_d = 1'b0;
            if (role_q == ROLE_ADDR && rw_q) begin
              load_tx = 1'b1;
            end else begin
              state_d = S_RX;
              bcnt_d  = 3'd0;
              case (role_q)
                ROLE_ADDR: role_d = ROLE_CMD;
                ROLE_CMD:  role_d = shreg_q[7] ? ROLE_DATA : ROLE_CNT;
                default:   role_d = ROLE_DATA;
              endcase
            end
          end
        end
        S_TX: begin
          if (scl_fall) begin
            if (bcnt_q == 3'd7) begin
              oe_d    = 1'b0;
              state_d = S_TX_ACK;
            end else begin
              bcnt_d  = bcnt_q + 3'd1;
              shreg_d = {shreg_q[6:0], 1'b0};
              oe_d    = ~shreg_q[6];
            end
          end
        end
        S_TX_ACK: begin
          if (scl_rise) begin
            state_d = sda_lvl ? S_SKIP : S_TX_NEXT;
          end
        end
        S_TX_NEXT: begin
          if (scl_fall) begin
            load_tx = 1'b1;
          end
        end
        default: oe_d = 1'b0;
      endcase
      if (load_tx) begin
        shreg_d = tx_byte;
        oe_d    = ~tx_byte[7];
        bcnt_d  = 3'd0;
        state_d = S_TX;
        if (send_cnt_q) begin
          send_cnt_d = 1'b0;
        end else begin
          ptr_d = ptr_next;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q    <= S_IDLE;
      role_q     <= ROLE_ADDR;
      bcnt_q     <= 3'd0;
      shreg_q    <= 8'd0;
      rw_q       <= 1'b0;
      ptr_q      <= '0;
      send_cnt_q <= 1'b0;
      wr_left_q  <= 8'd0;
      oe_q       <= 1'b0;
      we_q       <= 1'b0;
      waddr_q    <= '0;
      wdata_q    <= 8'd0;
    end else begin
      state_q    <= state_d;
      role_q     <= role_d;
      bcnt_q     <= bcnt_d;
      shreg_q    <= shreg_d;
      rw_q       <= rw_d;
      ptr_q      <= ptr_d;
      send_cnt_q <= send_cnt_d;
      wr_left_q  <= wr_left_d;
      oe_q       <= oe_d;
      we_q       <= we_d;
      waddr_q    <= waddr_d;
      wdata_q    <= wdata_d;
    end
  end

  assign sda_oe    = oe_q;
  assign reg_we    = we_q;
  assign reg_waddr = waddr_q;
  assign reg_wdata = wdata_q;
  assign reg_raddr = ptr_q[IDX_W-1:0];

  // R8
  sda_move_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !$stable(oe_q) |-> $past(scl_fall || start_evt || stop_evt));

  // R8
  idle_release_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (state_q == S_IDLE) |-> !oe_q);

  // R1
  skip_release_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (state_q == S_SKIP) |-> !oe_q);

  // R10
  we_pulse_chk: assert property (@(posedge clk) disable iff (!srst_n)
    we_q |=> !we_q);

  // R10
  we_origin_chk: assert property (@(posedge clk) disable iff (!srst_n)
    we_q |-> $past(scl_fall));

endmodule

// File: tb/smb_regbank_slave_tb.sv
module smb_regbank_slave_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NREG       = 32;
  localparam int IDX_W      = $clog2(NREG);
  localparam int HALF       = 20;
  localparam int NVEC       = 8;

  // {index, data}
  localparam logic [15:0] VEC [NVEC] = '{
    16'h00A5, 16'h015A, 16'h1FFF, 16'h0700,
    16'h1081, 16'h283C, 16'h7F77, 16'h05C3
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             scl_m = 1'b1;
  logic             sda_m = 1'b1;
  logic             sda_oe, reg_we;
  logic [IDX_W-1:0] reg_waddr, reg_raddr;
  logic [7:0]       reg_wdata, reg_rdata;
  logic             sda_bus;
  logic [7:0]       mem [NREG];

  int nchk = 0;
  int nerr = 0;
  int we_cnt = 0;
  int sda_viol = 0;
  int we_long = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sda_bus   = sda_m & ~sda_oe;
  assign reg_rdata = mem[reg_raddr];

  function automatic logic [7:0] defv(int i);
    return 8'(i * 13 + 7);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem[i] <= defv(i);
    end else if (reg_we) begin
      mem[reg_waddr] <= reg_wdata;
    end
  end

  smb_regbank_slave #(.NREG(NREG)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_m),
    .sda_i     (sda_bus),
    .sda_oe    (sda_oe),
    .reg_we    (reg_we),
    .reg_waddr (reg_waddr),
    .reg_wdata (reg_wdata),
    .reg_raddr (reg_raddr),
    .reg_rdata (reg_rdata)
  );

  // bus monitors (R8, R10)
  logic oe_prev = 1'b0;
  logic we_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (sda_oe != oe_prev && scl_m) sda_viol++;
      if (reg_we && we_prev) we_long++;
      if (reg_we) we_cnt++;
    end
    oe_prev = sda_oe;
    we_prev = reg_we;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wcyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    wcyc(4); sda_m = 1'b1; wcyc(HALF);
    scl_m = 1'b1; wcyc(HALF);
    sda_m = 1'b0; wcyc(HALF);
    scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    wcyc(4); sda_m = 1'b0; wcyc(HALF);
    scl_m = 1'b1; wcyc(HALF);
    sda_m = 1'b1; wcyc(HALF);
  endtask

  task automatic put_bit(input logic b);
    wcyc(4); sda_m = b; wcyc(HALF);
    scl_m = 1'b1; wcyc(HALF);
    scl_m = 1'b0;
  endtask

  task automatic get_bit(output logic b);
    wcyc(4); sda_m = 1'b1; wcyc(HALF);
    scl_m = 1'b1; wcyc(HALF/2);
    b = sda_bus; wcyc(HALF/2);
    scl_m = 1'b0;
  endtask

  // returns 1 when the slave acknowledged
  task automatic wr_byte(input logic [7:0] v, output bit ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic rd_byte(input bit last, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    put_bit(last);
  endtask

  task automatic idx_write(input logic [7:0] idx, input logic [7:0] d, output bit ok);
    bit a0, a1, a2;
    bus_start();
    wr_byte(8'hD2, a0);
    wr_byte(8'h80 | idx, a1);
    wr_byte(d, a2);
    bus_stop();
    ok = a0 & a1 & a2;
  endtask

  task automatic idx_read(input logic [7:0] idx, output logic [7:0] d, output bit ok);
    bit a0, a1, a2;
    bus_start();
    wr_byte(8'hD2, a0);
    wr_byte(8'h80 | idx, a1);
    bus_start();
    wr_byte(8'hD3, a2);
    rd_byte(1'b1, d);
    bus_stop();
    ok = a0 & a1 & a2;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nerr++;
      nchk++;
      $display("FAIL watchdog: actual=%0h expected=%0h", 0, 1);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    bit ok, a0, a1, a2, a3, a4, a5, a6;
    logic [7:0] rv, v0, v1, v2, keep7;
    int base;

    wcyc(5);
    // R9: released and quiet during and right after reset
    chk(sda_oe == 1'b0, "R9 sda_oe in reset", int'(sda_oe), 0);
    rst_n = 1'b1;
    wcyc(10);
    chk(sda_oe == 1'b0 && reg_we == 1'b0, "R9 outputs after reset",
        int'({sda_oe, reg_we}), 0);

    // table: indexed write then indexed read (R2, R3, R4, R7)
    for (int k = 0; k < NVEC; k++) begin
      logic [7:0] idx, dat, expv;
      idx  = VEC[k][15:8];
      dat  = VEC[k][7:0];
      expv = (idx < NREG) ? dat : 8'h00;
      base = we_cnt;
      idx_write(idx, dat, ok);
      chk(ok, "R2 indexed write acks", int'(ok), 1);
      chk((we_cnt - base) == ((idx < NREG) ? 1 : 0), "R7 write strobe count",
          we_cnt - base, (idx < NREG) ? 1 : 0);
      idx_read(idx, rv, ok);
      chk(ok && rv == expv, "R4 indexed read value", int'(rv), int'(expv));
    end

    // R1: foreign address is ignored
    base = we_cnt;
    bus_start();
    wr_byte(8'hA4, a0);
    wr_byte(8'h85, a1);
    wr_byte(8'h11, a2);
    bus_stop();
    chk(!a0 && !a1 && !a2, "R1 foreign address not acked", int'({a0, a1, a2}), 0);
    chk(we_cnt == base && mem[5] == 8'hC3, "R1 no write on foreign address",
        int'(mem[5]), 8'hC3);

    // R5: block write, count 3, one excess byte
    base = we_cnt;
    bus_start();
    wr_byte(8'hD2, a0);
    wr_byte(8'h00, a1);
    wr_byte(8'h03, a2);
    wr_byte(8'h11, a3);
    wr_byte(8'h22, a4);
    wr_byte(8'h33, a5);
    wr_byte(8'h44, a6);
    bus_stop();
    chk(a0 & a1 & a2 & a3 & a4 & a5 & a6, "R5 block write acks",
        int'({a0, a1, a2, a3, a4, a5, a6}), 8'h7F);
    chk(mem[0] == 8'h11 && mem[1] == 8'h22 && mem[2] == 8'h33, "R5 block data",
        int'({mem[0], mem[1], mem[2]}), 24'h112233);
    chk(mem[3] == defv(3) && (we_cnt - base) == 3, "R5 excess byte discarded",
        int'(mem[3]), int'(defv(3)));

    // R6: block read, count first, NACK on third data byte
    bus_start();
    wr_byte(8'hD2, a0);
    wr_byte(8'h00, a1);
    bus_start();
    wr_byte(8'hD3, a2);
    rd_byte(1'b0, rv);
    rd_byte(1'b0, v0);
    rd_byte(1'b0, v1);
    rd_byte(1'b1, v2);
    wcyc(HALF);
    chk(sda_oe == 1'b0, "R6 released after NACK", int'(sda_oe), 0);
    bus_stop();
    chk(a0 & a1 & a2, "R6 block read acks", int'({a0, a1, a2}), 7);
    chk(rv == 8'(NREG), "R6 count byte", int'(rv), NREG);
    chk({v0, v1, v2} == 24'h112233, "R6 ascending data",
        int'({v0, v1, v2}), 24'h112233);

    // R3: indexed write with extra bytes
    keep7 = mem[7];
    bus_start();
    wr_byte(8'hD2, a0);
    wr_byte(8'h86, a1);
    wr_byte(8'h9A, a2);
    wr_byte(8'hBB, a3);
    bus_stop();
    chk(a0 & a1 & a2 & a3, "R3 extra byte acked", int'({a0, a1, a2, a3}), 15);
    chk(mem[6] == 8'h9A && mem[7] == keep7, "R3 only first byte written",
        int'({mem[6], mem[7]}), int'({8'h9A, keep7}));
    idx_read(8'h06, rv, ok);
    chk(ok && rv == 8'h9A, "R2 index from command bits", int'(rv), 8'h9A);

    wcyc(10);
    chk(sda_oe == 1'b0, "R8 idle release", int'(sda_oe), 0);
    chk(sda_viol == 0, "R8 SDA drive moved with SCL high", sda_viol, 0);
    chk(we_long == 0, "R10 strobe longer than one cycle", we_long, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule